// File: doc/BRIEF.md
# Pipelined Hardwired Control Decoder

This block is the control unit of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It takes the 6-bit opcode that sits in the decode stage. It then carries a copy of that opcode, with a valid flag, through three stage registers: one each for execute, memory and writeback. Each stage drives its own control lines, and it decodes them from its own copy of the opcode. No decoded control word is handed from one stage to the next. The datapath these lines steer is outside the block.

The opcode is assigned bit by bit, so each bit names an instruction group. Decoding is therefore a small tree of gates and needs no lookup memory. The bits are named a to f from bit 5 down to bit 0:

| Bit | Name | Meaning |
|-----|------|---------|
| 5 | a | register form (1) or immediate form (0) |
| 4 | b | in immediate form, memory or immediate arithmetic (1) or control transfer (0) |
| 3, 2 | c, d | pick the individual instruction within a group |
| 1 | e | marks a shift within the register arithmetic group |
| 0 | f | picks set-on-compare (1) over arithmetic (0) |

A single advance input moves all stage copies together. When it is low, every stage holds.

The active-low reset clears the stage copies at once. Its release is synchronised to the clock by a short flop chain.

Top module: `pipe_ctl_decoder`

## Requirements
- R1: The decode-stage lines {id_b1,id_b2} are 10 for conditional-branch-on-zero (opcode 0x00), 11 for branch-on-nonzero (0x04), and 01 for both register jumps (0x08 plain, 0x0C linking). They are 00 for every other opcode and whenever id_vld is 0.
- R2: The execute-stage ex_alu_op is 0 add, 1 subtract, 2 and, 3 xor, 4 shift left, 5 shift right, 6 load-upper-immediate. The opcodes are add 0x20, sub 0x24, and 0x28, xor 0x2C, shift left 0x22, shift right 0x26, add-immediate 0x18, upper-immediate 0x1C. The three compares use subtract. Load (0x10) and store (0x14) use add. ex_imm_sel is 1 only for 0x18, 0x1C, 0x10 and 0x14.
- R3: In execute, ex_out1_ld is 1 for the eight arithmetic and immediate-arithmetic opcodes of R2. ex_out3_ld is 1 for the compares: equal 0x21, less 0x25, greater 0x29. For these, ex_set_fn is 0, 1 and 2 in that order. The two loads are never 1 together.
- R4: In memory, mem_out2_ld is 1 for every arithmetic, immediate-arithmetic and compare opcode. mem_out2_sel is 1 only for compares. mem_rd is 1 only for load (0x10) and mem_wr only for store (0x14).
- R5: In writeback, wb_src is one-hot with bit 0 for the ALU/compare result, bit 1 for the link value and bit 2 for loaded data. The ALU/compare result is used by the opcodes of R3. The link value is used by the linking jump 0x0C. Loaded data is used by load 0x10. wb_we is 1 exactly when a source is selected. Stores, branches and the plain jump select none.
- R6: Any opcode not named in R1 to R5, and any slot with the valid flag low, drives all enables to 0, ex_alu_op to 0 and the branch class to 00.
- R7: With the advance input high on each edge, an instruction shows its execute controls 1 edge after it was in decode, its memory controls after 2 edges, and its writeback controls after 3 edges.
- R8: An edge with adv low changes no stage copy. Execute, memory and writeback controls keep their values, whatever is on the decode inputs.
- R9: rst_n low clears all stage copies at once, whatever the clock does. After rst_n rises, the stages stay cleared until 2 rising clock edges have passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | pipeline clock |
| rst_n | input | 1 | asynchronous active-low reset |
| adv | input | 1 | advance all stage copies on this edge |
| id_vld | input | 1 | decode slot holds a real instruction |
| id_op | input | 6 | opcode in the decode stage |
| id_b1 | output | 1 | branch-class bit 1 (decode) |
| id_b2 | output | 1 | branch-class bit 2 (decode) |
| ex_alu_op | output | 3 | ALU function code (execute) |
| ex_imm_sel | output | 1 | second ALU operand is the immediate |
| ex_out1_ld | output | 1 | load the ALU result register |
| ex_out3_ld | output | 1 | load the compare result register |
| ex_set_fn | output | 2 | compare condition: 0 equal, 1 less, 2 greater |
| mem_out2_ld | output | 1 | load the memory-stage result register |
| mem_out2_sel | output | 1 | result source: 0 ALU, 1 compare |
| mem_rd | output | 1 | data memory read |
| mem_wr | output | 1 | data memory write |
| wb_src | output | 3 | one-hot write source: result, link, loaded data |
| wb_we | output | 1 | register file write enable |

## Verification
The assertions assume that adv and the decode inputs are stable around each rising edge. They also assume that rst_n is held low from time zero until the first edges have cleared the reset chain. The stage-shift and hold checks rely on adv alone deciding whether the copies move. The stimulus therefore changes id_op, id_vld and adv only on falling edges. It keeps adv low and id_vld low while the reset is released. It then covers every defined opcode, a spread of undefined ones, bubbles, and cycles in which a valid instruction waits under adv low.

// File: rtl/pipe_ctl_pkg.sv
`timescale 1ns/1ps
package pipe_ctl_pkg;

  localparam int OP_W   = 6;
  localparam int NSTG   = 4;   // decode, execute, memory, writeback
  localparam int ALU_W  = 3;
  localparam int FN_W   = 2;
  localparam int SRC_W  = 3;

  // writeback source bit positions
  localparam int SRC_RES  = 0;
  localparam int SRC_LINK = 1;
  localparam int SRC_LOAD = 2;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_XOR = 3'd3,
    ALU_SLL = 3'd4,
    ALU_SRL = 3'd5,
    ALU_LHI = 3'd6
  } alu_e;

  typedef struct packed {
    logic            vld;
    logic [OP_W-1:0] op;
  } stage_t;

  typedef struct packed {
    logic             b1;
    logic             b2;
    alu_e             alu;
    logic             imm_sel;
    logic             out1_ld;
    logic             out3_ld;
    logic [FN_W-1:0]  set_fn;
    logic             out2_ld;
    logic             out2_sel;
    logic             rd;
    logic             wr;
    logic [SRC_W-1:0] src;
    logic             we;
  } ctl_t;

endpackage

// File: rtl/pipe_ctl_rst_sync.sv
`timescale 1ns/1ps
module pipe_ctl_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[DEPTH-1];

endmodule

// File: rtl/pipe_ctl_stage_reg.sv
`timescale 1ns/1ps
module pipe_ctl_stage_reg
  import pipe_ctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_ni,
  input  logic   en,
  input  stage_t d,
  output stage_t q
);

  stage_t nxt;

  always_comb begin
    nxt = q;
    if (en) nxt = d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q.vld <= 1'b0;
      q.op  <= '0;
    end else begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/pipe_ctl_decode.sv
`timescale 1ns/1ps
module pipe_ctl_decode
  import pipe_ctl_pkg::*;
(
  input  stage_t slot,
  output ctl_t   ctl
);

  logic bit_a, bit_b, bit_c, bit_d, bit_e, bit_f;

  assign bit_a = slot.op[5];
  assign bit_b = slot.op[4];
  assign bit_c = slot.op[3];
  assign bit_d = slot.op[2];
  assign bit_e = slot.op[1];
  assign bit_f = slot.op[0];

  always_comb begin
    ctl = '0;
    if (slot.vld) begin
      if (bit_a) begin
        if (!bit_b) begin
          if (!bit_f && !bit_e) begin
            // register arithmetic, c/d pick the function
            ctl.alu     = alu_e'({1'b0, bit_c, bit_d});
            ctl.out1_ld = 1'b1;
            ctl.out2_ld = 1'b1;
            ctl.src[SRC_RES] = 1'b1;
            ctl.we      = 1'b1;
          end else if (!bit_f && bit_e && !bit_c) begin
            // shifts, d picks the direction
            ctl.alu     = bit_d ? ALU_SRL : ALU_SLL;
            ctl.out1_ld = 1'b1;
            ctl.out2_ld = 1'b1;
            ctl.src[SRC_RES] = 1'b1;
            ctl.we      = 1'b1;
          end else if (bit_f && !bit_e && !(bit_c && bit_d)) begin
            // compares, c/d pick the condition
            ctl.alu      = ALU_SUB;
            ctl.out3_ld  = 1'b1;
            ctl.set_fn   = {bit_c, bit_d};
            ctl.out2_ld  = 1'b1;
            ctl.out2_sel = 1'b1;
            ctl.src[SRC_RES] = 1'b1;
            ctl.we       = 1'b1;
          end
        end
      end else if (!bit_e && !bit_f) begin
        if (!bit_b) begin
          // control transfer
          ctl.b1 = !bit_c;
          ctl.b2 = bit_c | bit_d;
          if (bit_c && bit_d) begin
            ctl.src[SRC_LINK] = 1'b1;
            ctl.we            = 1'b1;
          end
        end else if (!bit_c) begin
          // memory access, address is base plus immediate
          ctl.alu     = ALU_ADD;
          ctl.imm_sel = 1'b1;
          if (bit_d) begin
            ctl.wr = 1'b1;
          end else begin
            ctl.rd = 1'b1;
            ctl.src[SRC_LOAD] = 1'b1;
            ctl.we = 1'b1;
          end
        end else begin
          // immediate arithmetic
          ctl.alu     = bit_d ? ALU_LHI : ALU_ADD;
          ctl.imm_sel = 1'b1;
          ctl.out1_ld = 1'b1;
          ctl.out2_ld = 1'b1;
          ctl.src[SRC_RES] = 1'b1;
          ctl.we      = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pipe_ctl_decoder.sv
`timescale 1ns/1ps
module pipe_ctl_decoder
  import pipe_ctl_pkg::*;
#(
  parameter int RST_SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             id_vld,
  input  logic [OP_W-1:0]  id_op,
  output logic             id_b1,
  output logic             id_b2,
  output logic [ALU_W-1:0] ex_alu_op,
  output logic             ex_imm_sel,
  output logic             ex_out1_ld,
  output logic             ex_out3_ld,
  output logic [FN_W-1:0]  ex_set_fn,
  output logic             mem_out2_ld,
  output logic             mem_out2_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [SRC_W-1:0] wb_src,
  output logic             wb_we
);

  localparam int ST_ID  = 0;
  localparam int ST_EX  = 1;
  localparam int ST_MEM = 2;
  localparam int ST_WB  = NSTG - 1;

  logic   rst_q_n;
  stage_t stg     [NSTG];
  ctl_t   st_ctl  [NSTG];

  pipe_ctl_rst_sync #(.DEPTH(RST_SYNC_DEPTH)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign stg[ST_ID].vld = id_vld;
  assign stg[ST_ID].op  = id_op;

  for (genvar s = 1; s < NSTG; s++) begin : g_stage
    pipe_ctl_stage_reg u_reg (
      .clk    (clk),
      .rst_ni (rst_q_n),
      .en     (adv),
      .d      (stg[s-1]),
      .q      (stg[s])
    );
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_dec
    pipe_ctl_decode u_dec (
      .slot (stg[s]),
      .ctl  (st_ctl[s])
    );
  end

  assign id_b1        = st_ctl[ST_ID].b1;
  assign id_b2        = st_ctl[ST_ID].b2;
  assign ex_alu_op    = st_ctl[ST_EX].alu;
  assign ex_imm_sel   = st_ctl[ST_EX].imm_sel;
  assign ex_out1_ld   = st_ctl[ST_EX].out1_ld;
  assign ex_out3_ld   = st_ctl[ST_EX].out3_ld;
  assign ex_set_fn    = st_ctl[ST_EX].set_fn;
  assign mem_out2_ld  = st_ctl[ST_MEM].out2_ld;
  assign mem_out2_sel = st_ctl[ST_MEM].out2_sel;
  assign mem_rd       = st_ctl[ST_MEM].rd;
  assign mem_wr       = st_ctl[ST_MEM].wr;
  assign wb_src       = st_ctl[ST_WB].src;
  assign wb_we        = st_ctl[ST_WB].we;

endmodule

// File: rtl/pipe_ctl_decoder_chk.sv
`timescale 1ns/1ps
module pipe_ctl_decoder_chk
  import pipe_ctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rst_q_n,
  input logic             adv,
  input ctl_t             st1,
  input ctl_t             st2,
  input ctl_t             st3,
  input logic             ex_out1_ld,
  input logic             ex_out3_ld,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic [SRC_W-1:0] wb_src,
  input logic             wb_we
);

  AST_WB_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> $onehot(wb_src)); // R5

  AST_WB_SRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_we |-> (wb_src == '0)); // R5

  AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && rst_q_n && mem_wr) |=> !wb_we); // R5

  AST_MEM_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R4

  AST_EX_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ex_out1_ld && ex_out3_ld)); // R3

  AST_STAGE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && rst_q_n) |=> ((st2 == $past(st1)) && (st3 == $past(st2)))); // R7

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(st1) && $stable(st2) && $stable(st3))); // R8

  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_q_n |-> ((st1 == '0) && (st2 == '0) && (st3 == '0))); // R9

endmodule

bind pipe_ctl_decoder pipe_ctl_decoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_q_n    (rst_q_n),
  .adv        (adv),
  .st1        (st_ctl[1]),
  .st2        (st_ctl[2]),
  .st3        (st_ctl[3]),
  .ex_out1_ld (ex_out1_ld),
  .ex_out3_ld (ex_out3_ld),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .wb_src     (wb_src),
  .wb_we      (wb_we)
);

// File: tb/pipe_ctl_decoder_tb.sv
`timescale 1ns/1ps
module pipe_ctl_decoder_tb;

  typedef struct packed {
    logic [1:0] br;
    logic [2:0] alu;
    logic       imm;
    logic       o1;
    logic       o3;
    logic [1:0] fn;
    logic       o2;
    logic       sel;
    logic       rd;
    logic       wr;
    logic [2:0] src;
    logic       we;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n, adv, id_vld;
  logic [5:0] id_op;
  logic       id_b1, id_b2;
  logic [2:0] ex_alu_op;
  logic       ex_imm_sel, ex_out1_ld, ex_out3_ld;
  logic [1:0] ex_set_fn;
  logic       mem_out2_ld, mem_out2_sel, mem_rd, mem_wr;
  logic [2:0] wb_src;
  logic       wb_we;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;
  string phase = "R1";
  exp_t sb[$];
  exp_t e_ex, e_mem, e_wb;

  always #2.5 clk = ~clk;

  pipe_ctl_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .adv(adv), .id_vld(id_vld), .id_op(id_op),
    .id_b1(id_b1), .id_b2(id_b2), .ex_alu_op(ex_alu_op), .ex_imm_sel(ex_imm_sel),
    .ex_out1_ld(ex_out1_ld), .ex_out3_ld(ex_out3_ld), .ex_set_fn(ex_set_fn),
    .mem_out2_ld(mem_out2_ld), .mem_out2_sel(mem_out2_sel), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .wb_src(wb_src), .wb_we(wb_we)
  );

  // reference behaviour, one entry per defined opcode
  function automatic exp_t ref_ctl(input logic [5:0] op, input logic vld);
    exp_t r = '0;
    if (vld) begin
      case (op)
        6'h20: begin r.alu = 3'd0; r.o1 = 1; r.o2 = 1; r.src = 3'b001; r.we = 1; end
        6'h24: begin r.alu = 3'd1; r.o1 = 1; r.o2 = 1; r.src = 3'b001; r.we = 1; end
        6'h28: begin r.alu = 3'd2; r.o1 = 1; r.o2 = 1; r.src = 3'b001; r.we = 1; end
        6'h2C: begin r.alu = 3'd3; r.o1 = 1; r.o2 = 1; r.src = 3'b001; r.we = 1; end
        6'h22: begin r.alu = 3'd4; r.o1 = 1; r.o2 = 1; r.src = 3'b001; r.we = 1; end
        6'h26: begin r.alu = 3'd5; r.o1 = 1; r.o2 = 1; r.src = 3'b001; r.we = 1; end
        6'h21: begin r.alu = 3'd1; r.o3 = 1; r.fn = 2'd0; r.o2 = 1; r.sel = 1; r.src = 3'b001; r.we = 1; end
        6'h25: begin r.alu = 3'd1; r.o3 = 1; r.fn = 2'd1; r.o2 = 1; r.sel = 1; r.src = 3'b001; r.we = 1; end
        6'h29: begin r.alu = 3'd1; r.o3 = 1; r.fn = 2'd2; r.o2 = 1; r.sel = 1; r.src = 3'b001; r.we = 1; end
        6'h00: r.br = 2'b10;
        6'h04: r.br = 2'b11;
        6'h08: r.br = 2'b01;
        6'h0C: begin r.br = 2'b01; r.src = 3'b010; r.we = 1; end
        6'h10: begin r.imm = 1; r.rd = 1; r.src = 3'b100; r.we = 1; end
        6'h14: begin r.imm = 1; r.wr = 1; end
        6'h18: begin r.alu = 3'd0; r.imm = 1; r.o1 = 1; r.o2 = 1; r.src = 3'b001; r.we = 1; end
        6'h1C: begin r.alu = 3'd6; r.imm = 1; r.o1 = 1; r.o2 = 1; r.src = 3'b001; r.we = 1; end
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [5:0] op, input logic vld, input logic a);
    exp_t r;
    @(negedge clk);
    id_op = op; id_vld = vld; adv = a;
    r = ref_ctl(op, vld);
    #1;
    chk({phase, " R1 decode class"}, {14'd0, id_b1, id_b2}, {14'd0, r.br});
    if (a) sb.push_back(r);
  endtask

  // scoreboard monitor: pops one expected item per advancing edge
  always @(posedge clk) begin
    if (mon_en) begin
      logic a_s;
      a_s = adv;
      #1;
      if (a_s) begin
        e_wb  = e_mem;
        e_mem = e_ex;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL %s R7 scoreboard empty got 0 expected 1", phase);
          e_ex = '0;
        end else begin
          e_ex = sb.pop_front();
        end
      end
      chk({phase, " R2/R3/R7 execute"},
          {7'd0, ex_alu_op, ex_imm_sel, ex_out1_ld, ex_out3_ld, ex_set_fn},
          {7'd0, e_ex.alu, e_ex.imm, e_ex.o1, e_ex.o3, e_ex.fn});
      chk({phase, " R4/R7 memory"},
          {12'd0, mem_out2_ld, mem_out2_sel, mem_rd, mem_wr},
          {12'd0, e_mem.o2, e_mem.sel, e_mem.rd, e_mem.wr});
      chk({phase, " R5/R7 writeback"},
          {12'd0, wb_src, wb_we}, {12'd0, e_wb.src, e_wb.we});
    end
  end

  task automatic chk_clear(input string tag);
    chk(tag, {ex_alu_op, ex_imm_sel, ex_out1_ld, ex_out3_ld, ex_set_fn,
              mem_out2_ld, mem_out2_sel, mem_rd, mem_wr, wb_src, wb_we}, 16'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] good [17];
    logic [5:0] bad  [9];
    good = '{6'h20, 6'h24, 6'h28, 6'h2C, 6'h22, 6'h26, 6'h21, 6'h25, 6'h29,
             6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C};
    bad  = '{6'h01, 6'h02, 6'h23, 6'h2A, 6'h2D, 6'h30, 6'h3F, 6'h11, 6'h1A};
    e_ex = '0; e_mem = '0; e_wb = '0;

    // r9_: reset held with a valid instruction advancing
    rst_n = 1'b0; adv = 1'b1; id_vld = 1'b1; id_op = 6'h10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_clear("R9 stages clear in reset");
    adv = 1'b0; id_vld = 1'b0; id_op = 6'h00;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_clear("R9 stages clear after release");
    mon_en = 1'b1;

    // R1..R5, R7: every defined opcode back to back
    phase = "R1-5";
    foreach (good[i]) issue(good[i], 1'b1, 1'b1);
    issue(6'h10, 1'b1, 1'b1);
    issue(6'h14, 1'b1, 1'b1);
    issue(6'h0C, 1'b1, 1'b1);
    issue(6'h25, 1'b1, 1'b1);

    // R6: undefined opcodes and invalid slots
    phase = "R6";
    foreach (bad[i]) issue(bad[i], 1'b1, 1'b1);
    issue(6'h20, 1'b0, 1'b1);
    issue(6'h0C, 1'b0, 1'b1);
    issue(6'h10, 1'b1, 1'b1);
    issue(6'h3E, 1'b1, 1'b1);

    // R8: stalls with valid instructions waiting in decode
    phase = "R8";
    issue(6'h20, 1'b1, 1'b1);
    issue(6'h10, 1'b1, 1'b0);
    issue(6'h10, 1'b1, 1'b0);
    issue(6'h14, 1'b1, 1'b1);
    issue(6'h0C, 1'b1, 1'b0);
    issue(6'h29, 1'b1, 1'b1);
    issue(6'h1C, 1'b1, 1'b0);
    issue(6'h1C, 1'b1, 1'b1);

    // R7: drain through the pipe
    phase = "R7";
    repeat (4) issue(6'h00, 1'b0, 1'b1);

    // r9_ asynchronous clear mid-run
    phase = "R9";
    issue(6'h10, 1'b1, 1'b1);
    issue(6'h24, 1'b1, 1'b1);
    @(negedge clk);
    mon_en = 1'b0;
    adv = 1'b0;
    chk("R9 memory holds load before reset", {15'd0, mem_rd}, 16'd1);
    rst_n = 1'b0;
    #1;
    chk_clear("R9 asynchronous clear");
    sb.delete();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule